// File: doc/BRIEF.md
# Quadrature Position Counter with Configuration Lock

This block turns the two phase signals of an incremental encoder into a position count. Both phase inputs are synchronised to the clock. Every single-phase edge is decoded as one step forward or backward, which gives four events per encoder cycle. A selectable power-of-two prescaler combines runs of events that go the same way before the position moves. The position runs between a start value and a limit value and wraps in both directions.

Software talks to the block over a simple word-indexed register port. Six registers are provided: configuration, position, limit, control, start and run. Reads are combinational and writes take effect on the next clock edge. The position cannot be written with data. Any write to it reloads the start value. A lock latch protects the configuration. The latch is set from the configuration register and cleared through a separate bit in the control register. The start and run registers also accept writes only while the unit-enable bit is set.

Top module: `qdec_timer`

## Requirements
- R1: After reset the lock is set, the position and start are 0, the limit is all ones, the prescale select is 0, and the unit-enable and run bits are 0. Reading configuration gives 0x40.
- R2: Phase pairs (A,B) stepping through 00→10→11→01→00, where A leads B, add one to the position per transition when the prescale select is 0.
- R3: The reverse order, 00→01→11→10→00, subtracts one per transition.
- R4: A sample in which A and B both change is not counted, and it produces no later count.
- R5: Bits [2:0] of configuration (index 0) select a divide of 2^n. The position moves once per 2^n consecutive events in one direction. An event in the other direction restarts the accumulation with itself as the first event. An accepted configuration write also clears the accumulation.
- R6: Counting up from the limit gives the start value. Counting down from the start gives the limit.
- R7: Any write to position (index 1) sets the position to the start value, whatever the data.
- R8: Writing 1 to configuration bit 6 sets the lock, and reads of bit 6 return it. Writing 1 to control (index 3) bit 2 clears it. While the lock is set, writes are ignored to the prescale field, limit (index 2), start (index 4), run (index 5) and control bit 0. This includes the write that clears the lock.
- R9: While the lock is clear, writes to start and run are still ignored unless control bit 0 (unit enable) is 1.
- R10: The position moves only while control bit 0 and run bit 0 are both 1. Phase edges at other times are tracked but not counted.
- R11: Reads return zero-extended fields: position, limit and start in bits [CNT_W-1:0], control bit 0, run bit 0, and configuration bits [2:0] and 6.
- R12: A phase change driven before clock edge k shows in a position read after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
A read result is due in the same cycle its index is driven. A register write is due after the edge that captures it. A phase change passes two synchroniser flops and the position register, so it is due three edges after the change is driven. The bench changes inputs and samples outputs on falling edges. After every phase change it waits four falling edges before reading. One directed check probes the exact three-edge latency by reading once after the second edge and once after the third.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned IDX_W = 3;
    localparam int unsigned PS_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        IX_CFG   = 3'd0,
        IX_POS   = 3'd1,
        IX_LIMIT = 3'd2,
        IX_CTRL  = 3'd3,
        IX_START = 3'd4,
        IX_QCTL  = 3'd5
    } reg_idx_e;

    localparam int unsigned CFG_LOCK_BIT    = 6;
    localparam int unsigned CTRL_EN_BIT     = 0;
    localparam int unsigned CTRL_UNLOCK_BIT = 2;
    localparam int unsigned QCTL_RUN_BIT    = 0;

    typedef struct packed {
        logic valid;
        logic up;
    } qevt_t;

    // forward when the new A level differs from the previous B level
    function automatic logic fwd_dir(input logic a_now, input logic b_old);
        return a_now ^ b_old;
    endfunction

    // true only when exactly one phase toggled
    function automatic logic one_changed(input logic a_now, input logic a_old,
                                         input logic b_now, input logic b_old);
        return (a_now ^ a_old) ^ (b_now ^ b_old);
    endfunction
endpackage

// File: rtl/qdec_phase_in.sv
module qdec_phase_in
    import qdec_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ph_a,
    input  logic  ph_b,
    output qevt_t evt
);
    logic [SYNC_STAGES-1:0] a_sr, b_sr;
    logic a_old, b_old;
    logic a_now, b_now;

    assign a_now = a_sr[SYNC_STAGES-1];
    assign b_now = b_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sr  <= '0;
            b_sr  <= '0;
            a_old <= 1'b0;
            b_old <= 1'b0;
        end else begin
            a_sr  <= {a_sr[SYNC_STAGES-2:0], ph_a};
            b_sr  <= {b_sr[SYNC_STAGES-2:0], ph_b};
            a_old <= a_now;
            b_old <= b_now;
        end
    end

    always_comb begin
        evt.valid = one_changed(a_now, a_old, b_now, b_old);
        evt.up    = fwd_dir(a_now, b_old);
    end
endmodule

// File: rtl/qdec_prescaler.sv
module qdec_prescaler
    import qdec_pkg::*;
#(
    parameter int unsigned SEL_W = PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  qevt_t            evt,
    input  logic [SEL_W-1:0] sel,
    output qevt_t            step
);
    localparam int unsigned ACC_W = 1 << SEL_W;

    logic [ACC_W-1:0] acc_q, acc_nx, target;
    logic             dir_q;

    assign target = ACC_W'(1) << sel;
    assign acc_nx = (evt.up == dir_q) ? acc_q + 1'b1 : ACC_W'(1);

    always_comb begin
        step.valid = evt.valid && (acc_nx == target);
        step.up    = evt.up;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            dir_q <= 1'b1;
        end else if (evt.valid) begin
            dir_q <= evt.up;
            acc_q <= step.valid ? '0 : acc_nx;
        end
    end
endmodule

// File: rtl/qdec_position.sv
module qdec_position
    import qdec_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  qevt_t            step,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    output logic [CNT_W-1:0] pos
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (load) begin
            pos <= lo;
        end else if (step.valid) begin
            if (step.up) pos <= (pos == hi) ? lo : pos + 1'b1;
            else         pos <= (pos == lo) ? hi : pos - 1'b1;
        end
    end
endmodule

// File: rtl/qdec_timer.sv
module qdec_timer
    import qdec_pkg::*;
#(
    parameter int unsigned     CNT_W     = 16,
    parameter int unsigned     SYNC_STGS = 2,
    parameter logic [CNT_W-1:0] LIMIT_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    logic [PS_W-1:0]  ps_q;
    logic             lock_q, en_q, qen_q, run_en;
    logic [CNT_W-1:0] limit_q, start_q, pos_q;
    reg_idx_e         ix;
    logic             wr_hit, wr_cfg, wr_pos, wr_limit, wr_ctrl, wr_start, wr_qctl;
    logic             wdata_unused;
    qevt_t            raw_evt, gated_evt, step;

    assign ix       = reg_idx_e'(bus_addr);
    assign wr_hit   = bus_sel && bus_wr;
    assign wr_cfg   = wr_hit && (ix == IX_CFG);
    assign wr_pos   = wr_hit && (ix == IX_POS);
    assign wr_limit = wr_hit && (ix == IX_LIMIT);
    assign wr_ctrl  = wr_hit && (ix == IX_CTRL);
    assign wr_start = wr_hit && (ix == IX_START);
    assign wr_qctl  = wr_hit && (ix == IX_QCTL);
    assign run_en   = en_q && qen_q;
    assign wdata_unused = ^bus_wdata[BUS_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q    <= '0;
            lock_q  <= 1'b1;
            limit_q <= LIMIT_RST;
            start_q <= '0;
            en_q    <= 1'b0;
            qen_q   <= 1'b0;
        end else begin
            if (wr_cfg) begin
                if (!lock_q) ps_q <= bus_wdata[PS_W-1:0];
                if (bus_wdata[CFG_LOCK_BIT]) lock_q <= 1'b1;
            end
            if (wr_ctrl) begin
                if (bus_wdata[CTRL_UNLOCK_BIT]) lock_q <= 1'b0;
                if (!lock_q) en_q <= bus_wdata[CTRL_EN_BIT];
            end
            if (wr_limit && !lock_q)         limit_q <= bus_wdata[CNT_W-1:0];
            if (wr_start && !lock_q && en_q) start_q <= bus_wdata[CNT_W-1:0];
            if (wr_qctl  && !lock_q && en_q) qen_q   <= bus_wdata[QCTL_RUN_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (ix)
            IX_CFG: begin
                bus_rdata[PS_W-1:0]    = ps_q;
                bus_rdata[CFG_LOCK_BIT] = lock_q;
            end
            IX_POS:   bus_rdata[CNT_W-1:0]   = pos_q;
            IX_LIMIT: bus_rdata[CNT_W-1:0]   = limit_q;
            IX_CTRL:  bus_rdata[CTRL_EN_BIT]  = en_q;
            IX_START: bus_rdata[CNT_W-1:0]   = start_q;
            IX_QCTL:  bus_rdata[QCTL_RUN_BIT] = qen_q;
            default:  bus_rdata = '0;
        endcase
    end

    qdec_phase_in #(.SYNC_STAGES(SYNC_STGS)) u_phase (
        .clk (clk),
        .rst (rst),
        .ph_a(ph_a),
        .ph_b(ph_b),
        .evt (raw_evt)
    );

    always_comb begin
        gated_evt.valid = raw_evt.valid && run_en;
        gated_evt.up    = raw_evt.up;
    end

    qdec_prescaler #(.SEL_W(PS_W)) u_presc (
        .clk (clk),
        .rst (rst),
        .clr (wr_cfg && !lock_q),
        .evt (gated_evt),
        .sel (ps_q),
        .step(step)
    );

    qdec_position #(.CNT_W(CNT_W)) u_pos (
        .clk (clk),
        .rst (rst),
        .load(wr_pos),
        .step(step),
        .lo  (start_q),
        .hi  (limit_q),
        .pos (pos_q)
    );
endmodule

// File: rtl/qdec_timer_chk.sv
module qdec_timer_chk
    import qdec_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [IDX_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic             lock_q,
    input logic             run_en,
    input logic [CNT_W-1:0] limit_q,
    input logic [CNT_W-1:0] start_q,
    input logic [CNT_W-1:0] pos_q
);
    // R7
    pos_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == IX_POS) |=> (pos_q == $past(start_q)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !(bus_sel && bus_wr && bus_addr == IX_POS)) |=> $stable(pos_q));

    // R8
    locked_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == IX_LIMIT && lock_q) |=> $stable(limit_q));

    // R8
    unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == IX_CTRL && bus_wdata[CTRL_UNLOCK_BIT]) |=> !lock_q);

    // R8
    lock_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == IX_CFG && bus_wdata[CFG_LOCK_BIT]) |=> lock_q);
endmodule

bind qdec_timer qdec_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_qdec_timer.sv
module tb_qdec_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ph_a = 1'b0, ph_b = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] v;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    qdec_timer dut (
        .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // {A, B, expected position}: up run, down run, wraps, simultaneous change
    localparam logic [17:0] VEC [13] = '{
        {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
        {2'b01, 16'h0003}, {2'b11, 16'h0002}, {2'b10, 16'h0001}, {2'b00, 16'h0000},
        {2'b01, 16'hFFFF}, {2'b00, 16'h0000}, {2'b11, 16'h0000}, {2'b01, 16'h0001},
        {2'b00, 16'h0002}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic set_ph(input logic a, input logic b);
        ph_a = a; ph_b = b;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R12 got=hang exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(0, v); chk("R1 cfg", v, 32'h40);
        rd(1, v); chk("R1 pos", v, 32'h0);
        rd(2, v); chk("R1 limit", v, 32'hFFFF);
        rd(4, v); chk("R1 start", v, 32'h0);
        rd(3, v); chk("R1 ctrl", v, 32'h0);
        rd(5, v); chk("R1 run", v, 32'h0);
        // R8 locked write ignored, unlock write ignores its other fields
        wr(2, 32'h10); rd(2, v); chk("R8 locked limit", v, 32'hFFFF);
        wr(3, 32'h5);  rd(3, v); chk("R8 unlock same-write", v, 32'h0);
        rd(0, v); chk("R8 unlocked", v, 32'h0);
        // R9 gated by unit enable
        wr(4, 32'h5); rd(4, v); chk("R9 start gated", v, 32'h0);
        wr(5, 32'h1); rd(5, v); chk("R9 run gated", v, 32'h0);
        wr(3, 32'h1); wr(5, 32'h1);
        rd(5, v); chk("R9 run accepted", v, 32'h1);

        // table walk: R2 R3 R4 R6
        for (int i = 0; i < 13; i++) begin
            set_ph(VEC[i][17], VEC[i][16]);
            rd(1, v);
            chk($sformatf("R2 R3 R4 R6 table step %0d", i), v, {16'h0, VEC[i][15:0]});
        end

        // R7 reload ignores data
        wr(1, 32'h1234); rd(1, v); chk("R7 reload", v, 32'h0);

        // R6 wrap with start 2 limit 5
        wr(4, 32'h2); wr(2, 32'h5); wr(1, 32'h0);
        rd(1, v); chk("R7 reload start", v, 32'h2);
        set_ph(1, 0); set_ph(1, 1); set_ph(0, 1);
        rd(1, v); chk("R6 at limit", v, 32'h5);
        set_ph(0, 0); rd(1, v); chk("R6 up wrap", v, 32'h2);
        set_ph(0, 1); rd(1, v); chk("R6 down wrap", v, 32'h5);

        // R5 divide by 4
        wr(0, 32'h2); wr(1, 32'h0);
        set_ph(0, 0); set_ph(1, 0); set_ph(1, 1);
        rd(1, v); chk("R5 three events", v, 32'h2);
        set_ph(0, 1); rd(1, v); chk("R5 fourth event", v, 32'h3);
        set_ph(0, 0);
        set_ph(0, 1); set_ph(1, 1); set_ph(1, 0);
        rd(1, v); chk("R5 direction restart", v, 32'h3);
        set_ph(0, 0); rd(1, v); chk("R5 down step", v, 32'h2);

        // R10 run bit off
        wr(0, 32'h0); wr(5, 32'h0);
        set_ph(1, 0); rd(1, v); chk("R10 stopped", v, 32'h2);
        wr(5, 32'h1);
        set_ph(1, 1); rd(1, v); chk("R10 resumed", v, 32'h3);

        // R8 lock
        wr(0, 32'h40); rd(0, v); chk("R8 lock set", v, 32'h40);
        wr(4, 32'h7); rd(4, v); chk("R8 start locked", v, 32'h2);
        wr(2, 32'h9); rd(2, v); chk("R8 limit locked", v, 32'h5);
        wr(5, 32'h0);
        set_ph(0, 1); rd(1, v); chk("R8 run write ignored", v, 32'h4);
        wr(3, 32'h4); rd(0, v); chk("R8 unlock", v, 32'h0);
        rd(3, v); chk("R8 enable kept", v, 32'h1);

        // R9 R10 with unit disabled
        wr(3, 32'h0);
        wr(4, 32'h9); rd(4, v); chk("R9 start disabled", v, 32'h2);
        set_ph(0, 0); rd(1, v); chk("R10 unit off", v, 32'h4);
        wr(3, 32'h1);
        wr(4, 32'h9); rd(4, v); chk("R9 start enabled", v, 32'h9);
        rd(2, v); chk("R11 limit read", v, 32'h5);

        // R12 latency
        ph_a = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1, v); chk("R12 after two edges", v, 32'h4);
        @(negedge clk);
        rd(1, v); chk("R12 after three edges", v, 32'h5);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule